// File: doc/BRIEF.md
# Short-Vector Iteration Sequencer with Exception Capture

This block steps a floating-point short-vector operation through its iterations. It accepts a length code, a stride code and an operation word that carries a destination and two source register numbers. It then presents one iteration at a time to an execute pipeline, giving the register addresses for each. An iteration starts every `ITER_CYCLES` cycles. Source operands that lie in the first register bank are held as scalars. All other addresses step by the stride and wrap inside their own bank.

The execute pipeline can mark the iteration currently on offer as potentially exceptional. When it does, the sequence stops and the block saves what software needs to resume the operation exactly:

- a status word with the exception flag, the reported condition flags and the count of iterations still to run, kept in a minus-one code;
- a copy of the operation word whose register fields are rewritten to address the faulting iteration.

If an instruction is waiting in decode when the exception is detected, the block bounces it in the next cycle. No further iterations issue, and no register writeback is enabled, until the exception flag is cleared.

Top module: `vsq_seq`

## Requirements
- R1: A start accepted in idle produces exactly `len_code`+1 iterations. Each iteration is shown for one cycle with `iss_valid` high.
- R2: The first iteration is offered in the cycle after the accepted start. Successive iterations are offered exactly `ITER_CYCLES` cycles apart (default 2).
- R3: Stride code 2'b11 gives a step of 2. Every other code gives a step of 1. A stepping address keeps its bank bits [3:2] and adds the step to bits [1:0] modulo 4.
- R4: A source register below 4 (first bank) stays at its base value for every iteration. The destination always steps.
- R5: When `exc_in` is high in an issue cycle, the next cycle shows the following status fields:
  - status bit 31 is set;
  - status bits [3:0] equal `exc_type`, with bit 0 invalid, bit 1 overflow, bit 2 underflow and bit 3 inexact;
  - status bit 28 (second captured word valid) is clear;
  - every bit not named here is zero.
- R6: Status bits [10:8] hold (iterations after the faulting one) minus 1, modulo 8. So 000 means one iteration remains and 111 means none remain.
- R7: The captured word equals the operation word with three fields replaced by the faulting iteration's registers: destination in bits [15:12], first source in bits [19:16] and second source in bits [3:0]. All other bits are unchanged.
- R8: `bounce` is a single-cycle pulse in the cycle after detection, and only if `dec_pending` was high in the detection cycle.
- R9: While status bit 31 is set, `iss_valid` and `wb_en` are low and `start` is ignored. A cycle with `exc_clr` high clears bit 31 and returns the block to idle.
- R10: `wb_en` is high in an issue cycle without `exc_in` and low in the faulting issue cycle.
- R11: `start` is ignored while a sequence is running.
- R12: After reset, `iss_valid`, `busy` and `bounce` are low, and the status word and captured word are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a vector operation |
| len_code | input | 3 | Iteration count minus one |
| stride_code | input | 2 | Stride select |
| inst_word | input | 32 | Operation word carrying base registers |
| exc_in | input | 1 | Offered iteration is potentially exceptional |
| exc_type | input | 4 | Condition flags reported with `exc_in` |
| dec_pending | input | 1 | An instruction is waiting in decode |
| exc_clr | input | 1 | Clear the exception flag |
| iss_valid | output | 1 | An iteration is offered this cycle |
| iss_dst | output | 4 | Destination register of the iteration |
| iss_srca | output | 4 | First source register |
| iss_srcb | output | 4 | Second source register |
| wb_en | output | 1 | Writeback permitted for this iteration |
| busy | output | 1 | Sequence in progress |
| bounce | output | 1 | Reject the decode-stage instruction |
| status | output | 32 | Exception status word |
| capt_word | output | 32 | Rewritten operation word |

## Verification
The main function is exercised with several operand patterns, each aimed at a different way the address logic could go wrong:

- a bank-1 destination starting mid-bank checks that wrap stays inside the bank;
- first-bank sources at both operand positions check scalar holding per operand;
- stride codes 00, 01 and 11 check the step decode;
- lengths 1, 4, 6 and 8 check the iteration count and the end of the sequence.

The exception points are chosen at the first, a middle and the last iteration, so the remaining-count code is seen at 000, at 011 and at its 111 wrap, and the rewritten word is seen with three different register sets. Runs with and without a pending decode instruction separate a correct bounce from one that is always or never raised.

// File: rtl/vsq_pkg.sv
package vsq_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_HALT = 2'd2
   } vsq_state_e;

   localparam int STAT_W   = 32;
   localparam int EXF_BIT  = 31;
   localparam int V2_BIT   = 28;
   localparam int REM_LSB  = 8;
endpackage

// File: rtl/vsq_opnd.sv
module vsq_opnd #(
   parameter int REG_W     = 4,
   parameter int IDX_W     = 2,
   parameter bit SCALAR_OK = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [REG_W-1:0] base,
   input  logic             step,
   input  logic [IDX_W-1:0] stride,
   output logic [REG_W-1:0] cur
);
   localparam int BANK_W = REG_W - IDX_W;

   logic hold;

   generate
      if (SCALAR_OK) begin : g_scalar
         logic hold_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    hold_q <= 1'b0;
            else if (load) hold_q <= (base[REG_W-1:IDX_W] == '0);
         end
         assign hold = hold_q;
      end else begin : g_vector
         assign hold = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur <= '0;
      end else if (load) begin
         cur <= base;
      end else if (step && !hold) begin
         cur <= {cur[REG_W-1 -: BANK_W], cur[IDX_W-1:0] + stride};
      end
   end
endmodule

// File: rtl/vsq_capt.sv
module vsq_capt
   import vsq_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int REG_W  = 4,
   parameter int LEN_W  = 3,
   parameter int FLAG_W = 4,
   parameter int DST_LSB  = 12,
   parameter int SRCA_LSB = 16,
   parameter int SRCB_LSB = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fire,
   input  logic              clr,
   input  logic [FLAG_W-1:0] flags,
   input  logic [LEN_W-1:0]  rem_code,
   input  logic [WORD_W-1:0] word,
   input  logic [REG_W-1:0]  dst,
   input  logic [REG_W-1:0]  srca,
   input  logic [REG_W-1:0]  srcb,
   output logic [STAT_W-1:0] status,
   output logic [WORD_W-1:0] capt_word
);
   logic [WORD_W-1:0] patched;
   logic [STAT_W-1:0] stat_new;

   always_comb begin
      patched = word;
      patched[DST_LSB  +: REG_W] = dst;
      patched[SRCA_LSB +: REG_W] = srca;
      patched[SRCB_LSB +: REG_W] = srcb;
   end

   always_comb begin
      stat_new = '0;
      stat_new[EXF_BIT]               = 1'b1;
      stat_new[V2_BIT]                = 1'b0;
      stat_new[REM_LSB +: LEN_W]      = rem_code;
      stat_new[FLAG_W-1:0]            = flags;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status    <= '0;
         capt_word <= '0;
      end else if (fire) begin
         status    <= stat_new;
         capt_word <= patched;
      end else if (clr) begin
         status[EXF_BIT] <= 1'b0;
      end
   end
endmodule

// File: rtl/vsq_seq.sv
module vsq_seq
   import vsq_pkg::*;
#(
   parameter int WORD_W      = 32,
   parameter int REG_W       = 4,
   parameter int IDX_W       = 2,
   parameter int LEN_W       = 3,
   parameter int FLAG_W      = 4,
   parameter int ITER_CYCLES = 2,
   parameter int DST_LSB     = 12,
   parameter int SRCA_LSB    = 16,
   parameter int SRCB_LSB    = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [LEN_W-1:0]  len_code,
   input  logic [1:0]        stride_code,
   input  logic [WORD_W-1:0] inst_word,
   input  logic              exc_in,
   input  logic [FLAG_W-1:0] exc_type,
   input  logic              dec_pending,
   input  logic              exc_clr,
   output logic              iss_valid,
   output logic [REG_W-1:0]  iss_dst,
   output logic [REG_W-1:0]  iss_srca,
   output logic [REG_W-1:0]  iss_srcb,
   output logic              wb_en,
   output logic              busy,
   output logic              bounce,
   output logic [STAT_W-1:0] status,
   output logic [WORD_W-1:0] capt_word
);
   localparam int CNT_W = (ITER_CYCLES > 1) ? $clog2(ITER_CYCLES) : 1;
   localparam logic [CNT_W-1:0] WAIT_RELOAD = CNT_W'(ITER_CYCLES - 1);

   generate
      if (ITER_CYCLES < 1) begin : g_bad_cycles
         $error("ITER_CYCLES must be at least 1");
      end
      if (IDX_W < 2 || REG_W <= IDX_W) begin : g_bad_regs
         $error("register index must leave room for a bank and hold stride 2");
      end
      if (LEN_W + REM_LSB > EXF_BIT || FLAG_W > REM_LSB) begin : g_bad_status
         $error("status fields overlap");
      end
      if (DST_LSB + REG_W > WORD_W || SRCA_LSB + REG_W > WORD_W || SRCB_LSB + REG_W > WORD_W) begin : g_bad_fields
         $error("register fields exceed the word");
      end
   endgenerate

   vsq_state_e        state;
   logic [LEN_W-1:0]  idx;
   logic [LEN_W-1:0]  len_q;
   logic [CNT_W-1:0]  wcnt;
   logic [WORD_W-1:0] word_q;
   logic [IDX_W-1:0]  stride_q;
   logic [IDX_W-1:0]  stride_dec;
   logic              accept;
   logic              fire;
   logic              advance;
   logic              bounce_q;

   assign stride_dec = (stride_code == 2'b11) ? IDX_W'(2) : IDX_W'(1);
   assign accept     = (state == ST_IDLE) && start;
   assign iss_valid  = (state == ST_RUN) && (wcnt == '0);
   assign fire       = iss_valid && exc_in;
   assign advance    = iss_valid && !exc_in && (idx != len_q);
   assign wb_en      = iss_valid && !exc_in;
   assign busy       = (state == ST_RUN);
   assign bounce     = bounce_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         idx      <= '0;
         len_q    <= '0;
         wcnt     <= '0;
         word_q   <= '0;
         stride_q <= '0;
         bounce_q <= 1'b0;
      end else begin
         bounce_q <= fire && dec_pending;
         unique case (state)
            ST_IDLE: if (start) begin
               state    <= ST_RUN;
               idx      <= '0;
               wcnt     <= '0;
               len_q    <= len_code;
               word_q   <= inst_word;
               stride_q <= stride_dec;
            end
            ST_RUN: begin
               if (wcnt != '0) begin
                  wcnt <= wcnt - 1'b1;
               end else if (exc_in) begin
                  state <= ST_HALT;
               end else if (idx == len_q) begin
                  state <= ST_IDLE;
               end else begin
                  idx  <= idx + 1'b1;
                  wcnt <= WAIT_RELOAD;
               end
            end
            ST_HALT: if (exc_clr) state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   vsq_opnd #(.REG_W(REG_W), .IDX_W(IDX_W), .SCALAR_OK(1'b0)) u_dst (
      .clk(clk), .rst_n(rst_n), .load(accept),
      .base(inst_word[DST_LSB +: REG_W]), .step(advance),
      .stride(stride_q), .cur(iss_dst));

   vsq_opnd #(.REG_W(REG_W), .IDX_W(IDX_W), .SCALAR_OK(1'b1)) u_srca (
      .clk(clk), .rst_n(rst_n), .load(accept),
      .base(inst_word[SRCA_LSB +: REG_W]), .step(advance),
      .stride(stride_q), .cur(iss_srca));

   vsq_opnd #(.REG_W(REG_W), .IDX_W(IDX_W), .SCALAR_OK(1'b1)) u_srcb (
      .clk(clk), .rst_n(rst_n), .load(accept),
      .base(inst_word[SRCB_LSB +: REG_W]), .step(advance),
      .stride(stride_q), .cur(iss_srcb));

   vsq_capt #(
      .WORD_W(WORD_W), .REG_W(REG_W), .LEN_W(LEN_W), .FLAG_W(FLAG_W),
      .DST_LSB(DST_LSB), .SRCA_LSB(SRCA_LSB), .SRCB_LSB(SRCB_LSB)
   ) u_capt (
      .clk(clk), .rst_n(rst_n), .fire(fire),
      .clr((state == ST_HALT) && exc_clr),
      .flags(exc_type), .rem_code(len_q - idx - 1'b1),
      .word(word_q), .dst(iss_dst), .srca(iss_srca), .srcb(iss_srcb),
      .status(status), .capt_word(capt_word));
endmodule

// File: rtl/vsq_seq_chk.sv
module vsq_seq_chk #(
   parameter int FLAG_W      = 4,
   parameter int ITER_CYCLES = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              iss_valid,
   input logic              exc_in,
   input logic [FLAG_W-1:0] exc_type,
   input logic              dec_pending,
   input logic              exc_clr,
   input logic              wb_en,
   input logic              bounce,
   input logic [31:0]       status
);
   generate
      if (ITER_CYCLES >= 2) begin : g_gap
         p_issue_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
            iss_valid |=> !iss_valid);
      end
   endgenerate

   p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && exc_in) |=> status[31]);

   p_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[31]) |-> (status[FLAG_W-1:0] == $past(exc_type)));

   p_bounce_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
      bounce |-> $past(iss_valid && exc_in && dec_pending));

   p_halt_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      status[31] |-> (!iss_valid && !wb_en));

   p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (status[31] && exc_clr) |=> !status[31]);
endmodule

bind vsq_seq vsq_seq_chk #(.FLAG_W(FLAG_W), .ITER_CYCLES(ITER_CYCLES)) u_chk (
   .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .exc_in(exc_in),
   .exc_type(exc_type), .dec_pending(dec_pending), .exc_clr(exc_clr),
   .wb_en(wb_en), .bounce(bounce), .status(status));

// File: tb/sim_vsq_seq.sv
`timescale 1ns/100ps
module sim_vsq_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [2:0]  len_code = '0;
   logic [1:0]  stride_code = '0;
   logic [31:0] inst_word = '0;
   logic        exc_in = 1'b0;
   logic [3:0]  exc_type = '0;
   logic        dec_pending = 1'b0;
   logic        exc_clr = 1'b0;
   logic        iss_valid, wb_en, busy, bounce;
   logic [3:0]  iss_dst, iss_srca, iss_srcb;
   logic [31:0] status, capt_word;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   vsq_seq u0 (.*);

   typedef struct packed {
      logic [2:0] len;
      logic [1:0] str;
      logic [3:0] dst;
      logic [3:0] sa;
      logic [3:0] sb;
      logic [3:0] exi;   // 4'hF: no exception
      logic [3:0] typ;
      logic       pend;
   } vec_t;

   localparam int NV = 6;
   localparam vec_t VECS [NV] = '{
      '{3'd3, 2'b00, 4'd8,  4'd12, 4'd8,  4'd2, 4'b0100, 1'b1},
      '{3'd3, 2'b00, 4'd9,  4'd2,  4'd13, 4'hF, 4'b0000, 1'b0},
      '{3'd3, 2'b11, 4'd4,  4'd5,  4'd1,  4'd3, 4'b0001, 1'b0},
      '{3'd0, 2'b00, 4'd12, 4'd0,  4'd3,  4'd0, 4'b0010, 1'b1},
      '{3'd7, 2'b11, 4'd15, 4'd6,  4'd10, 4'hF, 4'b0000, 1'b0},
      '{3'd5, 2'b01, 4'd7,  4'd14, 4'd11, 4'd1, 4'b1000, 1'b1}
   };
   localparam logic [31:0] WORD_BASE = 32'h5A70_0A50;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [3:0] step_reg(input logic [3:0] b, input int i, input int s, input bit scal);
      if (scal && b < 4) return b;
      return {b[3:2], 2'((int'(b[1:0]) + i * s) % 4)};
   endfunction

   function automatic logic [31:0] mk_word(input logic [3:0] d, input logic [3:0] a, input logic [3:0] b);
      return WORD_BASE | (32'(d) << 12) | (32'(a) << 16) | 32'(b);
   endfunction

   task automatic run_vec(input vec_t v);
      int s, k, last, n;
      bit done;
      logic [3:0] ed, ea, eb;
      logic [2:0] rem;
      s = (v.str == 2'b11) ? 2 : 1;
      n = int'(v.len) + 1;
      @(negedge clk);
      len_code = v.len; stride_code = v.str;
      inst_word = mk_word(v.dst, v.sa, v.sb);
      start = 1'b1;
      k = 0; last = -10; done = 0;
      for (int c = 0; c < 40 && !done; c++) begin
         @(negedge clk);
         start = 1'b0;
         if (c == 0) chk(iss_valid, "R2 first issue", 32'(iss_valid), 1);
         if (iss_valid) begin
            ed = step_reg(v.dst, k, s, 0);
            ea = step_reg(v.sa, k, s, 1);
            eb = step_reg(v.sb, k, s, 1);
            chk(iss_dst == ed, "R3 dst address", 32'(iss_dst), 32'(ed));
            chk(iss_srca == ea, "R4 srca address", 32'(iss_srca), 32'(ea));
            chk(iss_srcb == eb, "R4 srcb address", 32'(iss_srcb), 32'(eb));
            if (k > 0) chk(c - last == 2, "R2 issue spacing", 32'(c - last), 2);
            last = c;
            if (k == int'(v.exi)) begin
               exc_in = 1'b1; exc_type = v.typ; dec_pending = v.pend;
               #1 chk(!wb_en, "R10 wb_en low on fault", 32'(wb_en), 0);
               @(negedge clk);
               exc_in = 1'b0; dec_pending = 1'b0;
               rem = 3'(int'(v.len) - k - 1);
               chk(status == ((32'd1 << 31) | (32'(rem) << 8) | 32'(v.typ)),
                   "R5 R6 status word", status, (32'd1 << 31) | (32'(rem) << 8) | 32'(v.typ));
               chk(capt_word == mk_word(ed, ea, eb), "R7 captured word", capt_word, mk_word(ed, ea, eb));
               chk(bounce == v.pend, "R8 bounce", 32'(bounce), 32'(v.pend));
               // halted: start ignored, nothing issues, bounce single pulse
               start = 1'b1;
               for (int h = 0; h < 4; h++) begin
                  @(negedge clk);
                  start = 1'b0;
                  chk(!iss_valid && !wb_en && !busy, "R9 halted quiet", {iss_valid, wb_en, busy}, 0);
                  if (h == 0) chk(!bounce, "R8 bounce one cycle", 32'(bounce), 0);
               end
               exc_clr = 1'b1;
               @(negedge clk);
               exc_clr = 1'b0;
               chk(!status[31], "R9 flag cleared", 32'(status[31]), 0);
               chk(status[30:0] == ((32'(rem) << 8) | 32'(v.typ)), "R9 fields kept", {1'b0, status[30:0]}, (32'(rem) << 8) | 32'(v.typ));
               done = 1;
            end else begin
               #1 chk(wb_en, "R10 wb_en on issue", 32'(wb_en), 1);
            end
            k++;
         end else if (!busy) begin
            done = 1;
         end
      end
      if (v.exi == 4'hF) begin
         chk(k == n, "R1 iteration count", 32'(k), 32'(n));
         chk(!status[31], "R1 no exception", 32'(status[31]), 0);
      end
   endtask

   initial begin
      #100000;
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int k;
      repeat (3) @(negedge clk);
      chk(!iss_valid && !busy && !bounce, "R12 reset outputs", {iss_valid, busy, bounce}, 0);
      chk(status == 0, "R12 reset status", status, 0);
      chk(capt_word == 0, "R12 reset captured word", capt_word, 0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) run_vec(VECS[i]);

      // R11: a second start during a run is ignored
      @(negedge clk);
      len_code = 3'd1; stride_code = 2'b00; inst_word = mk_word(4'd4, 4'd4, 4'd4);
      start = 1'b1;
      @(negedge clk);
      start = 1'b1; len_code = 3'd7;
      k = 0;
      for (int c = 0; c < 20; c++) begin
         if (iss_valid) k++;
         @(negedge clk);
         start = 1'b0;
      end
      chk(k == 2, "R11 restart ignored", 32'(k), 2);

      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule